// File: doc/BRIEF.md
# UART Host Register File with Baud Divisor

This block is the processor-facing side of an asynchronous serial port. A host reaches eight byte-wide locations through a 3-bit offset with separate read and write strobes. The block keeps the frame-format, modem-output, interrupt-mask, queue-setup and scratch bytes. It returns the live status presented by the serial datapath. It also turns accesses at offset 0 into single-cycle push and pop strobes for the transmit and receive queues.

Bit 7 of the frame-format byte is the divisor-access switch. While it is set, offsets 0 and 1 stop reaching the data path and the interrupt mask. They reach the low and high bytes of a 16-bit divisor instead. That divisor drives a counter which emits one oversampling enable every `divisor` clocks, so a bit lasts 16 enables. The divisor equals f_clk / (16 × baud). For example, 120 gives 9600 baud from 18.432 MHz and 10 gives 115200.

The serial side is inhibited after reset. No queue is pushed or popped until the host writes the queue-setup byte with its enable bit set; the usual setup value is 0x07.

Top module: `uart_regfile`

## Requirements
- R1: After reset the frame-format byte, divisor, interrupt mask, modem-output byte and scratch byte are all 0, the serial path is disabled, and a read of offset 5 with transmitter-empty and transmitter-idle status high returns 0x60.
- R2: Offset 5 reads {any error, tx_idle, tx_empty, rx_err[3:0], rx_ready}. Offset 6 reads modem_stat unchanged.
- R3: While bit 7 of the frame-format byte is 1, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte, and neither access pushes or pops a queue or changes the interrupt mask.
- R4: With bit 7 clear and the path enabled, a write to offset 0 raises tx_push with tx_data equal to the written byte in that same cycle, and a read of offset 0 returns rx_data and raises rx_pop in that cycle.
- R5: Until the queue-setup byte has been written with bit 0 set, offset 0 accesses raise neither tx_push nor rx_pop.
- R6: A queue-setup write with bit 1 set gives a one-cycle rx_fifo_clr pulse in the following cycle, and bit 2 does the same for tx_fifo_clr. Bits 7:6 are held as rx_trig and bit 0 as comm_en.
- R7: With a nonzero divisor N, baud_tick is high once every N cycles; with divisor 0 it never rises.
- R8: Writing either divisor byte restarts the counter, so the first enable comes N−1 cycles after the write edge, N being the new divisor.
- R9: Interrupt mask (4 bits), modem-output (5 bits), frame-format and scratch bytes read back what was written, with unimplemented upper bits reading 0.
- R10: A read of offset 2 returns {comm_en, comm_en, 2'b00, irq_id}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| tx_push | output | 1 | Push to transmit queue |
| tx_data | output | 8 | Byte to push |
| rx_pop | output | 1 | Pop from receive queue |
| rx_data | input | 8 | Head of receive queue |
| rx_ready | input | 1 | Receive data available |
| rx_err | input | 4 | Overrun, parity, framing, break flags |
| tx_empty | input | 1 | Transmit holding empty |
| tx_idle | input | 1 | Transmitter fully idle |
| irq_id | input | 4 | Pending interrupt code |
| modem_stat | input | 8 | Modem input status |
| line_ctrl | output | 8 | Frame-format byte |
| int_en | output | 4 | Interrupt mask |
| modem_ctrl | output | 5 | Modem-output byte |
| comm_en | output | 1 | Serial path enabled |
| rx_fifo_clr | output | 1 | Receive queue clear pulse |
| tx_fifo_clr | output | 1 | Transmit queue clear pulse |
| rx_trig | output | 2 | Receive trigger level |
| baud_tick | output | 1 | 16x oversampling enable |

## Verification
A divisor byte write can land in the same cycle in which the counter reaches zero and baud_tick is high. The bench waits for a tick while the divisor is 6 and writes a new low byte of 4 in exactly that cycle. It expects the tick to be seen in that cycle and the next one to come three edges later, not on the old period. A second case writes in the cycle just after a tick. It shows that the restart overrides the count still in progress.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int BYTE_W = 8;
  localparam int DIV_W  = 2 * BYTE_W;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_MASK  = 3'd1;
  localparam logic [OFS_W-1:0] OFS_QCTL  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_FMT   = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MOUT  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;

  localparam int DLAB_BIT = 7;

  typedef struct packed {
    logic wr_tx;
    logic rd_rx;
    logic wr_div_lo;
    logic wr_div_hi;
    logic wr_mask;
    logic wr_qctl;
    logic wr_fmt;
    logic wr_mout;
    logic wr_scr;
  } rf_strobe_t;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
(
  input  logic [OFS_W-1:0] addr,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             dlab,
  input  logic             path_on,
  output rf_strobe_t       stb
);
  always_comb begin
    stb = '0;
    unique case (addr)
      OFS_DATA: begin
        stb.wr_div_lo = wr_en & dlab;
        stb.wr_tx     = wr_en & ~dlab & path_on;
        stb.rd_rx     = rd_en & ~dlab & path_on;
      end
      OFS_MASK: begin
        stb.wr_div_hi = wr_en & dlab;
        stb.wr_mask   = wr_en & ~dlab;
      end
      OFS_QCTL: stb.wr_qctl = wr_en;
      OFS_FMT:  stb.wr_fmt  = wr_en;
      OFS_MOUT: stb.wr_mout = wr_en;
      OFS_SCR:  stb.wr_scr  = wr_en;
      default:  stb = '0;
    endcase
  end
endmodule

// File: rtl/uart_rf_baud.sv
module uart_rf_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic [DIV_W-1:0] div_d,
  input  logic             load,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (load)
      cnt_d = (div_d == '0) ? '0 : div_d - 1'b1;
    else if (div_q == '0)
      cnt_d = '0;
    else if (cnt_q == '0)
      cnt_d = div_q - 1'b1;
    else
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (div_q != '0) && (cnt_q == '0);
endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_rf_pkg::*;
#(
  parameter int MASK_W = 4,
  parameter int MOUT_W = 5,
  parameter int IRQ_W  = 4,
  parameter int ERR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              tx_push,
  output logic [7:0]        tx_data,
  output logic              rx_pop,
  input  logic [7:0]        rx_data,
  input  logic              rx_ready,
  input  logic [ERR_W-1:0]  rx_err,
  input  logic              tx_empty,
  input  logic              tx_idle,
  input  logic [IRQ_W-1:0]  irq_id,
  input  logic [7:0]        modem_stat,
  output logic [7:0]        line_ctrl,
  output logic [MASK_W-1:0] int_en,
  output logic [MOUT_W-1:0] modem_ctrl,
  output logic              comm_en,
  output logic              rx_fifo_clr,
  output logic              tx_fifo_clr,
  output logic [1:0]        rx_trig,
  output baud_tick
);
  localparam int QID_PAD = BYTE_W - 2 - IRQ_W;

  rf_strobe_t stb;

  logic [BYTE_W-1:0] fmt_q, fmt_d, scr_q, scr_d;
  logic [MASK_W-1:0] mask_q, mask_d;
  logic [MOUT_W-1:0] mout_q, mout_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic              en_q, en_d;
  logic              rclr_q, rclr_d, tclr_q, tclr_d;
  logic [1:0]        trig_q, trig_d;
  logic              div_load;

  uart_rf_decode u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .dlab    (fmt_q[DLAB_BIT]),
    .path_on (en_q),
    .stb     (stb)
  );

  // next-state
  always_comb begin
    fmt_d  = stb.wr_fmt  ? wdata : fmt_q;
    scr_d  = stb.wr_scr  ? wdata : scr_q;
    mask_d = stb.wr_mask ? wdata[MASK_W-1:0] : mask_q;
    mout_d = stb.wr_mout ? wdata[MOUT_W-1:0] : mout_q;
    div_d  = div_q;
    if (stb.wr_div_lo) div_d[BYTE_W-1:0]     = wdata;
    if (stb.wr_div_hi) div_d[DIV_W-1:BYTE_W] = wdata;
    en_d   = stb.wr_qctl ? wdata[0] : en_q;
    trig_d = stb.wr_qctl ? wdata[7:6] : trig_q;
    rclr_d = stb.wr_qctl & wdata[1];
    tclr_d = stb.wr_qctl & wdata[2];
  end

  assign div_load = stb.wr_div_lo | stb.wr_div_hi;

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q  <= '0;
      scr_q  <= '0;
      mask_q <= '0;
      mout_q <= '0;
      div_q  <= '0;
      en_q   <= 1'b0;
      trig_q <= '0;
      rclr_q <= 1'b0;
      tclr_q <= 1'b0;
    end else begin
      fmt_q  <= fmt_d;
      scr_q  <= scr_d;
      mask_q <= mask_d;
      mout_q <= mout_d;
      div_q  <= div_d;
      en_q   <= en_d;
      trig_q <= trig_d;
      rclr_q <= rclr_d;
      tclr_q <= tclr_d;
    end
  end

  uart_rf_baud #(.DIV_W(DIV_W)) u_baud (
    .clk   (clk),
    .rst_n (rst_n),
    .div_q (div_q),
    .div_d (div_d),
    .load  (div_load),
    .tick  (baud_tick)
  );

  // read mux
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      unique case (addr)
        OFS_DATA:  rdata = fmt_q[DLAB_BIT] ? div_q[BYTE_W-1:0] : rx_data;
        OFS_MASK:  rdata = fmt_q[DLAB_BIT] ? div_q[DIV_W-1:BYTE_W] : BYTE_W'(mask_q);
        OFS_QCTL:  rdata = {en_q, en_q, {QID_PAD{1'b0}}, irq_id};
        OFS_FMT:   rdata = fmt_q;
        OFS_MOUT:  rdata = BYTE_W'(mout_q);
        OFS_LSTAT: rdata = {|rx_err, tx_idle, tx_empty, rx_err, rx_ready};
        OFS_MSTAT: rdata = modem_stat;
        OFS_SCR:   rdata = scr_q;
        default:   rdata = '0;
      endcase
    end
  end

  assign tx_push     = stb.wr_tx;
  assign tx_data     = wdata;
  assign rx_pop      = stb.rd_rx;
  assign line_ctrl   = fmt_q;
  assign int_en      = mask_q;
  assign modem_ctrl  = mout_q;
  assign comm_en     = en_q;
  assign rx_fifo_clr = rclr_q;
  assign tx_fifo_clr = tclr_q;
  assign rx_trig     = trig_q;
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  addr,
  input logic        wr_en,
  input logic [7:0]  wdata,
  input logic        tx_push,
  input logic        rx_pop,
  input logic        comm_en,
  input logic [7:0]  line_ctrl,
  input logic        rx_fifo_clr,
  input logic        tx_fifo_clr,
  input logic        baud_tick,
  input logic [15:0] div_q
);
  assert_push_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push || rx_pop) |-> comm_en);

  assert_no_queue_in_dlab_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_push || rx_pop) |-> !line_ctrl[7]);

  assert_rx_clr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fifo_clr |-> $past(wr_en && addr == 3'd2 && wdata[1]));

  assert_tx_clr_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fifo_clr |-> $past(wr_en && addr == 3'd2 && wdata[2]));

  assert_tick_needs_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> div_q != 16'd0);

  assert_tick_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && $past(baud_tick)) |-> div_q == 16'd1);

  assert_fmt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd3) |=> $stable(line_ctrl));
endmodule

bind uart_regfile uart_regfile_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr        (addr),
  .wr_en       (wr_en),
  .wdata       (wdata),
  .tx_push     (tx_push),
  .rx_pop      (rx_pop),
  .comm_en     (comm_en),
  .line_ctrl   (line_ctrl),
  .rx_fifo_clr (rx_fifo_clr),
  .tx_fifo_clr (tx_fifo_clr),
  .baud_tick   (baud_tick),
  .div_q       (div_q)
);

// File: tb/uart_regfile_test.sv
module uart_regfile_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, tx_data, line_ctrl;
  logic       tx_push, rx_pop;
  logic [7:0] rx_data = 8'h3C;
  logic       rx_ready = 1'b0;
  logic [3:0] rx_err = '0;
  logic       tx_empty = 1'b1, tx_idle = 1'b1;
  logic [3:0] irq_id = 4'h2;
  logic [7:0] modem_stat = 8'h96;
  logic [3:0] int_en;
  logic [4:0] modem_ctrl;
  logic       comm_en, rx_fifo_clr, tx_fifo_clr, baud_tick;
  logic [1:0] rx_trig;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  uart_regfile uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tx_push(tx_push), .tx_data(tx_data),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_ready(rx_ready), .rx_err(rx_err),
    .tx_empty(tx_empty), .tx_idle(tx_idle), .irq_id(irq_id),
    .modem_stat(modem_stat), .line_ctrl(line_ctrl), .int_en(int_en),
    .modem_ctrl(modem_ctrl), .comm_en(comm_en), .rx_fifo_clr(rx_fifo_clr),
    .tx_fifo_clr(tx_fifo_clr), .rx_trig(rx_trig), .baud_tick(baud_tick)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive at negedge, clock it in, release at next negedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d, output logic pop);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata; pop = rx_pop;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic edges_to_tick(output int k);
    k = 0;
    while (!baud_tick && k < 1000) begin
      @(posedge clk); @(negedge clk); k++;
    end
  endtask

  task automatic t_reset;
    logic [7:0] d; logic p;
    check("R1 fmt", line_ctrl, 0);
    check("R1 mask", int_en, 0);
    check("R1 comm_en", comm_en, 0);
    check("R1 no tick", baud_tick, 0);
    rd(3'd5, d, p); check("R1 lstat", d, 8'h60);
    rd(3'd7, d, p); check("R1 scratch", d, 0);
  endtask

  task automatic t_regs;
    logic [7:0] d; logic p;
    wr(3'd1, 8'hFF); rd(3'd1, d, p); check("R9 mask", d, 8'h0F);
    wr(3'd4, 8'hFF); rd(3'd4, d, p); check("R9 mout", d, 8'h1F);
    check("R9 modem_ctrl port", modem_ctrl, 5'h1F);
    wr(3'd7, 8'hA5); rd(3'd7, d, p); check("R9 scratch", d, 8'hA5);
    wr(3'd3, 8'h0A); rd(3'd3, d, p); check("R9 fmt", d, 8'h0A);
    rd(3'd6, d, p); check("R2 mstat", d, 8'h96);
    rx_ready = 1'b1; rx_err = 4'b0100; tx_empty = 1'b0;
    rd(3'd5, d, p); check("R2 lstat", d, 8'hC9);
    rx_ready = 1'b0; rx_err = '0; tx_empty = 1'b1;
  endtask

  task automatic t_gate;
    logic [7:0] d; logic p;
    addr = 3'd0; wdata = 8'h11; wr_en = 1'b1; #1;
    check("R5 no push", tx_push, 0);
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    rd(3'd0, d, p); check("R5 no pop", p, 0);
    rd(3'd2, d, p); check("R10 iir off", d, 8'h02);
  endtask

  task automatic t_qctl;
    logic [7:0] d; logic p;
    addr = 3'd2; wdata = 8'h87; wr_en = 1'b1;
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    check("R6 comm_en", comm_en, 1);
    check("R6 rx clr", rx_fifo_clr, 1);
    check("R6 tx clr", tx_fifo_clr, 1);
    check("R6 trig", rx_trig, 2);
    @(posedge clk); @(negedge clk);
    check("R6 rx clr once", rx_fifo_clr, 0);
    check("R6 tx clr once", tx_fifo_clr, 0);
    rd(3'd2, d, p); check("R10 iir on", d, 8'hC2);
  endtask

  task automatic t_push_pop;
    logic [7:0] d; logic p;
    addr = 3'd0; wdata = 8'h5A; wr_en = 1'b1; #1;
    check("R4 push", tx_push, 1);
    check("R4 tx_data", tx_data, 8'h5A);
    @(posedge clk); @(negedge clk); wr_en = 1'b0; #1;
    check("R4 push single", tx_push, 0);
    rd(3'd0, d, p);
    check("R4 rx data", d, 8'h3C);
    check("R4 pop", p, 1);
  endtask

  task automatic t_dlab;
    logic [7:0] d; logic p;
    wr(3'd3, 8'h8A);
    addr = 3'd0; wdata = 8'h78; wr_en = 1'b1; #1;
    check("R3 no push dlab", tx_push, 0);
    @(posedge clk); @(negedge clk); wr_en = 1'b0;
    wr(3'd1, 8'h01);
    rd(3'd0, d, p); check("R3 div lo", d, 8'h78); check("R3 no pop dlab", p, 0);
    rd(3'd1, d, p); check("R3 div hi", d, 8'h01);
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h0A);
    rd(3'd1, d, p); check("R3 mask kept", d, 8'h0F);
  endtask

  task automatic t_baud;
    int k;
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h00);
    repeat (40) begin
      @(posedge clk); @(negedge clk);
      if (baud_tick) k = 99;
    end
    check("R7 div zero quiet", (k == 99) ? 1 : 0, 0);
    wr(3'd0, 8'h04);
    edges_to_tick(k); check("R8 first tick", k, 3);
    @(posedge clk); @(negedge clk);
    edges_to_tick(k); check("R7 period 4", k + 1, 4);
  endtask

  task automatic t_reload;
    int k;
    wr(3'd0, 8'h06);
    edges_to_tick(k);
    @(posedge clk); @(negedge clk);
    wr(3'd0, 8'h03);
    edges_to_tick(k); check("R8 restart mid", k, 2);
    wr(3'd0, 8'h06);
    edges_to_tick(k);
    check("R8 tick before collide", baud_tick, 1);
    wr(3'd0, 8'h04);
    edges_to_tick(k); check("R8 collide", k, 3);
    wr(3'd3, 8'h0A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_gate();
    t_qctl();
    t_push_pop();
    t_dlab();
    t_baud();
    t_reload();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule